// File: doc/BRIEF.md
# Interrupt Status and Mask Register Set

This block holds the interrupt state of a serial peripheral. Seven hardware event lines feed a sticky status register. Software sees that register through a plain address/write-enable/data register port. Whether each source may raise the interrupt line is held in a mask. The mask is never written directly. Software sets bits through an enable port and clears bits through a separate disable port, so one agent can change a single source without a read-modify-write. The mask itself can be read back through a read-only view.

Status bits are cleared by writing ones to the status address. The usual handler reads the status word and writes the same value back, which clears exactly the events it has seen. The single interrupt output is a level: it stays high while any source is both latched and enabled. All four addresses use one bit layout:

| Bit | Event |
|-----|-------|
| 1 | mode fault |
| 2 | transmit level above watermark |
| 3 | transmit queue full |
| 4 | receive queue holds data |
| 0, 5, 6 | general-purpose |

Top module: `spi_irq_regs`

## Requirements
- R1: While rst_ni is low and after its release, status and mask are all zero, irq_o is low and every read returns zero.
- R2: An event_i bit that is high at a clock edge sets the matching status bit at that edge. The bit stays set after the event line drops.
- R3: A write to address 0x04 clears each status bit whose data bit is 1 and leaves status bits under 0 data bits unchanged.
- R4: If an event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: A write to address 0x08 sets each mask bit whose data bit is 1 and leaves the other mask bits unchanged.
- R6: A write to address 0x0C clears each mask bit whose data bit is 1 and leaves the other mask bits unchanged. Writing 0x7F there disables all seven sources in one write.
- R7: A read of address 0x10 returns the mask (bit n = source n enabled). A write to 0x10 leaves the mask and the status unchanged.
- R8: A read of address 0x04 returns the status (bit n = source n latched), with the mode fault on bit 1, the watermark event on bit 2, transmit full on bit 3 and receive not empty on bit 4.
- R9: Reads of 0x08, 0x0C and any unmapped address return zero. Writes to unmapped addresses change nothing.
- R10: irq_o is high exactly when some bit is set in both status and mask, and it holds as a level until that condition ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register byte address |
| wr_en_i | input | 1 | Write strobe for the current address |
| wdata_i | input | 7 | Write data |
| rdata_o | output | 7 | Read data for addr_i, combinational |
| event_i | input | 7 | Hardware event lines, one per source |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench targets the same-cycle collision of an event with a clearing write to that bit. A design that lets the clear win would lose an interrupt, and the status read in the next cycle would show the bit as zero. It also checks partial-bit writes to the enable and disable ports. A design that loads the mask from the data word, instead of merging into it, would drop bits that were already enabled. Reads of the write-only ports and of unmapped addresses must return zero, and writes to the mask view must be ignored; a loose address decode would show up as stray read data or a changed mask. A long run of random traffic checks that irq_o follows the status-and-mask overlap in every cycle, including while an event is held high during a clear.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_STAT = 2'd1,
    RD_MASK = 2'd2
  } rd_sel_e;
endpackage

// File: rtl/spi_irq_dec.sv
module spi_irq_dec
  import spi_irq_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          NUM_SRC  = 7,
  parameter logic [ADDR_W-1:0] OFF_STAT = 8'h04,
  parameter logic [ADDR_W-1:0] OFF_EN   = 8'h08,
  parameter logic [ADDR_W-1:0] OFF_DIS  = 8'h0C,
  parameter logic [ADDR_W-1:0] OFF_MASK = 8'h10
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_en_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] stat_clr_o,
  output logic [NUM_SRC-1:0] mask_set_o,
  output logic [NUM_SRC-1:0] mask_clr_o,
  output rd_sel_e            rd_sel_o
);
  logic hit_stat, hit_en, hit_dis, hit_mask;

  assign hit_stat = (addr_i == OFF_STAT);
  assign hit_en   = (addr_i == OFF_EN);
  assign hit_dis  = (addr_i == OFF_DIS);
  assign hit_mask = (addr_i == OFF_MASK);

  assign stat_clr_o = (wr_en_i && hit_stat) ? wdata_i : '0;
  assign mask_set_o = (wr_en_i && hit_en)   ? wdata_i : '0;
  assign mask_clr_o = (wr_en_i && hit_dis)  ? wdata_i : '0;

  // enable/disable ports are write-only: they read as zero
  always_comb begin
    if (hit_stat)      rd_sel_o = RD_STAT;
    else if (hit_mask) rd_sel_o = RD_MASK;
    else               rd_sel_o = RD_NONE;
  end
endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status #(
  parameter int NUM_SRC = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] event_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] status_o
);
  logic [NUM_SRC-1:0] status_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         status_q[g] <= 1'b0;
      else if (event_i[g]) status_q[g] <= 1'b1;  // set beats clear
      else if (clr_i[g])   status_q[g] <= 1'b0;
    end
  end

  assign status_o = status_q;

  p_event_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_i != '0) |=> ((status_q & $past(event_i)) == $past(event_i)));

  p_clear_lands_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~event_i) != '0) |=> ((status_q & $past(clr_i & ~event_i)) == '0));

  p_fall_needs_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i == '0) |=> ((~status_q & $past(status_q)) == '0));

  p_collision_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & event_i) != '0) |=> ((status_q & $past(clr_i & event_i)) == $past(clr_i & event_i)));
endmodule

// File: rtl/spi_irq_mask.sv
module spi_irq_mask #(
  parameter int NUM_SRC = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] mask_o
);
  logic [NUM_SRC-1:0] mask_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       mask_q[g] <= 1'b0;
      else if (set_i[g]) mask_q[g] <= 1'b1;
      else if (clr_i[g]) mask_q[g] <= 1'b0;
    end
  end

  assign mask_o = mask_q;

  p_enable_sets_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((mask_q & $past(set_i)) == $past(set_i)));

  p_disable_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i != '0) |=> ((mask_q & $past(clr_i)) == '0));

  p_idle_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i == '0 && clr_i == '0) |=> $stable(mask_q));
endmodule

// File: rtl/spi_irq_regs.sv
module spi_irq_regs
  import spi_irq_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int NUM_SRC = 7,
  parameter logic [ADDR_W-1:0] OFF_STAT = 8'h04,
  parameter logic [ADDR_W-1:0] OFF_EN   = 8'h08,
  parameter logic [ADDR_W-1:0] OFF_DIS  = 8'h0C,
  parameter logic [ADDR_W-1:0] OFF_MASK = 8'h10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_en_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] rdata_o,
  input  logic [NUM_SRC-1:0] event_i,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] stat_clr, mask_set, mask_clr;
  logic [NUM_SRC-1:0] status, mask;
  rd_sel_e            rd_sel;

  spi_irq_dec #(
    .ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC),
    .OFF_STAT(OFF_STAT), .OFF_EN(OFF_EN), .OFF_DIS(OFF_DIS), .OFF_MASK(OFF_MASK)
  ) i_dec (
    .addr_i    (addr_i),
    .wr_en_i   (wr_en_i),
    .wdata_i   (wdata_i),
    .stat_clr_o(stat_clr),
    .mask_set_o(mask_set),
    .mask_clr_o(mask_clr),
    .rd_sel_o  (rd_sel)
  );

  spi_irq_status #(.NUM_SRC(NUM_SRC)) i_status (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .event_i (event_i),
    .clr_i   (stat_clr),
    .status_o(status)
  );

  spi_irq_mask #(.NUM_SRC(NUM_SRC)) i_mask (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (mask_set),
    .clr_i (mask_clr),
    .mask_o(mask)
  );

  always_comb begin
    unique case (rd_sel)
      RD_STAT: rdata_o = status;
      RD_MASK: rdata_o = mask;
      default: rdata_o = '0;
    endcase
  end

  assign irq_o = |(status & mask);

  p_no_irq_unmasked_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask == '0) |-> !irq_o);

  p_irq_follows_event_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((event_i & mask & ~mask_clr) != '0) |=> irq_o);

  p_wo_reads_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == OFF_EN || addr_i == OFF_DIS) |-> (rdata_o == '0));

  always_comb begin
    if (!rst_ni) p_reset_quiet_r1: assert (!irq_o || $isunknown(irq_o));
  end
endmodule

// File: tb/test_spi_irq_regs.sv
module test_spi_irq_regs;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = 8'h00;
  logic       we = 1'b0;
  logic [6:0] wdata = '0;
  logic [6:0] ev = '0;
  logic [6:0] rdata;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  int m_st = 0;
  int m_mk = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  spi_irq_regs i_spi_irq_regs (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .event_i(ev), .irq_o(irq)
  );

  function automatic int exp_rd(input logic [7:0] a);
    if (a == 8'h04) return m_st;
    if (a == 8'h10) return m_mk;
    return 0;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // drive one cycle, compare mid low phase, then advance the model over the edge
  task automatic step(input logic [7:0] a, input bit w, input logic [6:0] d,
                      input logic [6:0] e, input string tag);
    int clr;
    @(negedge clk);
    addr = a; we = w; wdata = d; ev = e;
    #1;
    check(tag, "rdata", int'(rdata), exp_rd(a));
    check(tag, "irq", int'(irq), ((m_st & m_mk) != 0) ? 1 : 0);
    clr = (w && a == 8'h04) ? int'(d) : 0;
    m_st = (m_st & ~clr) | int'(e);
    if (w && a == 8'h08) m_mk = m_mk | int'(d);
    if (w && a == 8'h0C) m_mk = m_mk & ~int'(d);
    @(posedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    addr = 8'h04; #1;
    check("R1", "status in reset", int'(rdata), 0);
    check("R1", "irq in reset", int'(irq), 0);
    ev = 7'h7F; @(posedge clk); #1;
    check("R1", "status held by reset", int'(rdata), 0);
    ev = '0;
    @(negedge clk); rst_n = 1'b1;
    step(8'h10, 0, 0, 0, "R1");
    step(8'h04, 0, 0, 0, "R1");
    // R2/R8: sticky set, bit layout (mode fault bit1, rx not empty bit4)
    step(8'h04, 0, 0, 7'h12, "R2");
    step(8'h04, 0, 0, 0, "R8");
    check("R8", "status layout", int'(rdata), 7'h12);
    // R5: enable bits 1 and 2 -> irq on via bit 1
    step(8'h08, 1, 7'h06, 0, "R5");
    step(8'h10, 0, 0, 0, "R5");
    check("R10", "irq level", int'(irq), 1);
    step(8'h08, 1, 7'h20, 0, "R5");
    step(8'h10, 0, 0, 0, "R5");
    // R3: clear bit 1 only
    step(8'h04, 1, 7'h02, 0, "R3");
    step(8'h04, 0, 0, 0, "R3");
    check("R3", "partial clear", int'(rdata), 7'h10);
    check("R10", "irq dropped", int'(irq), 0);
    // R4: collision, set wins
    step(8'h04, 1, 7'h10, 7'h10, "R4");
    step(8'h04, 0, 0, 0, "R4");
    check("R4", "set beats clear", int'(rdata), 7'h10);
    // R6: partial disable then all
    step(8'h0C, 1, 7'h02, 0, "R6");
    step(8'h10, 0, 0, 0, "R6");
    check("R6", "partial disable", int'(rdata), 7'h24);
    step(8'h0C, 1, 7'h7F, 0, "R6");
    step(8'h10, 0, 0, 0, "R6");
    check("R6", "disable all", int'(rdata), 0);
    // R7: mask view ignores writes
    step(8'h10, 1, 7'h7F, 0, "R7");
    step(8'h10, 0, 0, 0, "R7");
    check("R7", "mask write ignored", int'(rdata), 0);
    // R9: write-only and unmapped addresses
    step(8'h08, 1, 7'h08, 0, "R9");
    step(8'h0C, 0, 0, 0, "R9");
    step(8'h00, 1, 7'h7F, 0, "R9");
    step(8'h14, 1, 7'h7F, 0, "R9");
    step(8'h10, 0, 0, 0, "R9");
    check("R9", "unmapped write no effect", int'(rdata), 7'h08);
    // random traffic, R10 compared every cycle
    for (int i = 0; i < 600; i++) begin
      logic [7:0] a;
      case ($urandom % 6)
        0: a = 8'h04; 1: a = 8'h08; 2: a = 8'h0C;
        3: a = 8'h10; 4: a = 8'h00; default: a = 8'h1C;
      endcase
      step(a, ($urandom % 2) == 0, 7'($urandom), ($urandom % 4 == 0) ? 7'($urandom) : 7'h00, "R10");
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule